// File: doc/BRIEF.md
# Double-Buffered Coefficient Memory Controller

This block keeps two complete copies of a filter's coefficient set, bank A and bank B, so that a host can prepare a new set while a filter engine keeps reading the other one. The engine always reads the active bank. A status pin shows which bank that is: 0 means bank A and 1 means bank B. The active bank changes only on a sample-period boundary, so every coefficient used within one sample period comes from the same bank.

The host has a parallel coefficient port with a bank select and an index. A separate control write sets the adaptive-mode enable and raises a swap request. When the engine is stopped, the host port reaches exactly the bank it names. When the engine runs with adaptive mode off, the coefficients are locked and every host access is refused. When the engine runs with adaptive mode on, host accesses are steered to the bank that is not active, whichever bank the host names. A swap request then takes effect at the next sample-period start.

Both data ports follow valid-only rules and have no back-pressure. A request is accepted in the cycle in which its valid (`host_valid` or `eng_rd`) is high. Each accepted read returns exactly one response one cycle later, flagged by `host_rvalid` or `eng_rvalid`. The receiver must take that response in that cycle.

Top module: `dbl_coef_mem`

## Requirements
- R1: After reset, `active_bank` is 0 (bank A), `adapt_en` is 0 and `swap_pend` is 0, and every entry of both banks reads as zero.
- R2: While `eng_run` is 0, a host write updates the entry at `host_idx` in the bank named by `host_bank` (0 = A, 1 = B). A host read returns that entry from the named bank.
- R3: While `eng_run` is 1 and `adapt_en` is 0, a host access leaves both banks unchanged. It produces no `host_rvalid` and raises `host_err` for one cycle, in the cycle after the request.
- R4: While `eng_run` is 1 and `adapt_en` is 1, host writes and reads use the bank opposite to `active_bank`, whatever the value of `host_bank`.
- R5: A control write with `ctl_swap`=1, made while `eng_run` and the new adaptive enable are both 1, sets `swap_pend`. The active bank stays the same until a cycle with `eng_sp_start`=1. On the edge of that cycle, `active_bank` toggles and `swap_pend` returns to 0.
- R6: A swap request is dropped, and `swap_pend` is 0 in the next cycle, whenever `eng_run` is 0 or adaptive mode is off. This holds both when the request is made and when either condition drops later. A dropped request never changes `active_bank`.
- R7: An engine read (`eng_rd`=1) gives `eng_rvalid`=1 in the next cycle. `eng_rdata` then holds the entry at `eng_idx` from the bank that was active in the request cycle.
- R8: An index of `DEPTH` or more (default 128) is out of range. A host access with such an index changes no entry, including the entry its low bits alias. It raises `host_err` for one cycle in the next cycle. An engine read with such an index returns zero.
- R9: An accepted host read gives `host_rvalid` in the next cycle. `host_rvalid` and `host_err` are never high together.
- R10: A control write loads `adapt_en` from `ctl_adapt`. `adapt_en` keeps its value whether or not the engine is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host coefficient request valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_bank | input | 1 | Named bank, 0 = A, 1 = B |
| host_idx | input | IDX_W (8) | Coefficient index |
| host_wdata | input | DW (16) | Write data |
| host_rvalid | output | 1 | Host read response valid |
| host_rdata | output | DW (16) | Host read response data |
| host_err | output | 1 | One-cycle pulse for a refused or out-of-range access |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_adapt | input | 1 | Adaptive-mode enable value for the control write |
| ctl_swap | input | 1 | Swap request bit for the control write |
| adapt_en | output | 1 | Adaptive-mode enable state |
| swap_pend | output | 1 | Swap request pending; clears itself when the swap happens |
| active_bank | output | 1 | Bank used by the engine, 0 = A, 1 = B |
| eng_run | input | 1 | Engine running level |
| eng_sp_start | input | 1 | Sample-period start strobe |
| eng_rd | input | 1 | Engine read request |
| eng_idx | input | IDX_W (8) | Engine read index |
| eng_rvalid | output | 1 | Engine read response valid |
| eng_rdata | output | DW (16) | Engine read data |

## Verification
The bench uses the same host write and read in each of three regimes: engine stopped, engine running with the lock in place, and engine running in adaptive mode. This tells apart named-bank access, refusal, and steering to the idle bank. Pattern values that differ for each bank and each phase show whether a write landed in the wrong bank. Engine reads taken before and after a sample-period strobe, with a request pending, show whether the swap waits for the boundary. Requests dropped by clearing adaptive mode or stopping the engine must leave the active bank unchanged. Index 127 and indices above the depth check the range limit and the aliasing of the low bits.

// File: rtl/coef_pkg.sv
package coef_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;
  localparam int NBANK = 2;
endpackage

// File: rtl/coef_bank.sv
module coef_bank #(
  parameter int DEPTH = 128,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          h_re,
  input  logic [AW-1:0] h_addr,
  output logic [DW-1:0] h_rdata,
  input  logic          e_re,
  input  logic [AW-1:0] e_addr,
  output logic [DW-1:0] e_rdata
);
  logic [DW-1:0] mem [DEPTH];

  // storage cleared on reset, one write port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // registered read ports
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rdata <= '0;
      e_rdata <= '0;
    end else begin
      if (h_re) h_rdata <= mem[h_addr];
      if (e_re) e_rdata <= mem[e_addr];
    end
  end
endmodule

// File: rtl/coef_ctrl.sv
module coef_ctrl
  import coef_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_wr,
  input  logic  ctl_adapt,
  input  logic  ctl_swap,
  input  logic  eng_run,
  input  logic  eng_sp_start,
  output logic  adapt_en,
  output logic  swap_pend,
  output bank_e active
);
  logic adapt_nx, swap_now, pend_nx;

  always_comb begin
    adapt_nx = ctl_wr ? ctl_adapt : adapt_en;
    swap_now = swap_pend & eng_sp_start & eng_run & adapt_en;
    // a request survives only while the engine runs in adaptive mode
    pend_nx  = ((swap_pend & ~swap_now) | (ctl_wr & ctl_swap)) & eng_run & adapt_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adapt_en  <= 1'b0;
      swap_pend <= 1'b0;
      active    <= BANK_A;
    end else begin
      adapt_en  <= adapt_nx;
      swap_pend <= pend_nx;
      if (swap_now) active <= (active == BANK_A) ? BANK_B : BANK_A;
    end
  end
endmodule

// File: rtl/dbl_coef_mem.sv
module dbl_coef_mem
  import coef_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_valid,
  input  logic             host_we,
  input  logic             host_bank,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [DW-1:0]    host_wdata,
  output logic             host_rvalid,
  output logic [DW-1:0]    host_rdata,
  output logic             host_err,
  input  logic             ctl_wr,
  input  logic             ctl_adapt,
  input  logic             ctl_swap,
  output logic             adapt_en,
  output logic             swap_pend,
  output logic             active_bank,
  input  logic             eng_run,
  input  logic             eng_sp_start,
  input  logic             eng_rd,
  input  logic [IDX_W-1:0] eng_idx,
  output logic             eng_rvalid,
  output logic [DW-1:0]    eng_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

  bank_e active;
  assign active_bank = active;

  coef_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_adapt(ctl_adapt), .ctl_swap(ctl_swap),
    .eng_run(eng_run), .eng_sp_start(eng_sp_start),
    .adapt_en(adapt_en), .swap_pend(swap_pend), .active(active)
  );

  // host access decode
  logic  h_in_range, e_in_range, locked, h_ok, h_wr, h_rd;
  bank_e h_tgt;

  always_comb begin
    h_in_range = {1'b0, host_idx} < LIMIT;
    e_in_range = {1'b0, eng_idx} < LIMIT;
    locked     = eng_run & ~adapt_en;
    h_ok       = host_valid & h_in_range & ~locked;
    h_wr       = h_ok & host_we;
    h_rd       = h_ok & ~host_we;
    // while running, the named bank is ignored: the idle bank is used
    if (eng_run) h_tgt = (active == BANK_A) ? BANK_B : BANK_A;
    else         h_tgt = bank_e'(host_bank);
  end

  logic [DW-1:0] h_rd_b [NBANK];
  logic [DW-1:0] e_rd_b [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    coef_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(h_wr && (h_tgt == bank_e'(b))),
      .waddr(host_idx[AW-1:0]), .wdata(host_wdata),
      .h_re(h_rd && (h_tgt == bank_e'(b))),
      .h_addr(host_idx[AW-1:0]), .h_rdata(h_rd_b[b]),
      .e_re(eng_rd && e_in_range && (active == bank_e'(b))),
      .e_addr(eng_idx[AW-1:0]), .e_rdata(e_rd_b[b])
    );
  end

  // response pipeline
  bank_e h_sel_q, e_sel_q;
  logic  e_zero_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_err    <= 1'b0;
      h_sel_q     <= BANK_A;
      eng_rvalid  <= 1'b0;
      e_sel_q     <= BANK_A;
      e_zero_q    <= 1'b0;
    end else begin
      host_rvalid <= h_rd;
      host_err    <= host_valid & ~(h_in_range & ~locked);
      if (h_rd) h_sel_q <= h_tgt;
      eng_rvalid  <= eng_rd;
      if (eng_rd) begin
        e_sel_q  <= active;
        e_zero_q <= ~e_in_range;
      end
    end
  end

  assign host_rdata = host_rvalid ? h_rd_b[h_sel_q] : '0;
  assign eng_rdata  = (eng_rvalid && !e_zero_q) ? e_rd_b[e_sel_q] : '0;
endmodule

// File: rtl/coef_mem_chk.sv
module coef_mem_chk #(
  parameter int DEPTH = 128,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_valid,
  input logic [IDX_W-1:0] host_idx,
  input logic             host_rvalid,
  input logic             host_err,
  input logic             adapt_en,
  input logic             swap_pend,
  input logic             active_bank,
  input logic             eng_run,
  input logic             eng_sp_start,
  input logic             eng_rd,
  input logic             eng_rvalid
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

  // R5
  swap_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_bank != $past(active_bank)) |-> $past(eng_sp_start && swap_pend));

  // R5
  swap_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_pend && eng_sp_start && eng_run && adapt_en) |=> (active_bank != $past(active_bank)));

  // R6
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_run |=> !swap_pend);

  // R7
  eng_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rd |=> eng_rvalid);

  // R7
  eng_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_rd |=> !eng_rvalid);

  // R8
  oor_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && ({1'b0, host_idx} >= LIMIT)) |=> (host_err && !host_rvalid));

  // R3
  locked_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && eng_run && !adapt_en) |=> (host_err && !host_rvalid));

  // R9
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rvalid && host_err));
endmodule

bind dbl_coef_mem coef_mem_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_idx(host_idx),
  .host_rvalid(host_rvalid), .host_err(host_err), .adapt_en(adapt_en),
  .swap_pend(swap_pend), .active_bank(active_bank), .eng_run(eng_run),
  .eng_sp_start(eng_sp_start), .eng_rd(eng_rd), .eng_rvalid(eng_rvalid)
);

// File: tb/tb_dbl_coef_mem.sv
module tb_dbl_coef_mem;
  localparam int DEPTH = 128;
  localparam int DW    = 16;
  localparam int IDX_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 0, host_we = 0, host_bank = 0;
  logic [IDX_W-1:0] host_idx = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_rvalid, host_err;
  logic [DW-1:0] host_rdata;
  logic ctl_wr = 0, ctl_adapt = 0, ctl_swap = 0;
  logic adapt_en, swap_pend, active_bank;
  logic eng_run = 0, eng_sp_start = 0, eng_rd = 0;
  logic [IDX_W-1:0] eng_idx = '0;
  logic eng_rvalid;
  logic [DW-1:0] eng_rdata;

  always #2 clk = ~clk;

  dbl_coef_mem #(.DEPTH(DEPTH), .DW(DW), .IDX_W(IDX_W)) dut (.*);

  int vectors = 0, miscompares = 0;
  logic [DW-1:0] ma [DEPTH];
  logic [DW-1:0] mb [DEPTH];
  logic m_run = 0, m_adapt = 0, m_pend = 0, m_act = 0;
  logic [DW-1:0] hq [$];
  logic [DW-1:0] eq [$];
  string hq_tag [$];
  string eq_tag [$];

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_status(input string tag);
    chk(active_bank == m_act, {tag, " active_bank"}, {15'd0, active_bank}, {15'd0, m_act});
    chk(swap_pend == m_pend, {tag, " swap_pend"}, {15'd0, swap_pend}, {15'd0, m_pend});
    chk(adapt_en == m_adapt, {tag, " adapt_en"}, {15'd0, adapt_en}, {15'd0, m_adapt});
  endtask

  // driver: host access, model update and expected response
  task automatic host_op(input logic we, input logic bank, input int idx, input logic [DW-1:0] d, input string tag);
    logic ok;
    logic tgt;
    ok  = (idx < DEPTH) && !(m_run && !m_adapt);
    tgt = m_run ? ~m_act : bank;
    host_valid = 1; host_we = we; host_bank = bank;
    host_idx = IDX_W'(idx); host_wdata = d;
    if (ok && we) begin
      if (tgt) mb[idx] = d; else ma[idx] = d;
    end
    if (ok && !we) begin
      hq.push_back(tgt ? mb[idx] : ma[idx]);
      hq_tag.push_back(tag);
    end
    @(negedge clk);
    chk(host_err == !ok, {tag, " host_err"}, {15'd0, host_err}, {15'd0, !ok});
    host_valid = 0; host_we = 0;
  endtask

  task automatic eng_read(input int idx, input string tag);
    eng_rd = 1; eng_idx = IDX_W'(idx);
    eq.push_back((idx < DEPTH) ? (m_act ? mb[idx] : ma[idx]) : '0);
    eq_tag.push_back(tag);
    @(negedge clk);
    eng_rd = 0;
  endtask

  task automatic ctl(input logic a, input logic s, input string tag);
    ctl_wr = 1; ctl_adapt = a; ctl_swap = s;
    m_adapt = a;
    m_pend = (m_pend | s) & m_run & m_adapt;
    @(negedge clk);
    ctl_wr = 0; ctl_swap = 0;
    chk_status(tag);
  endtask

  task automatic set_run(input logic r, input string tag);
    eng_run = r; m_run = r;
    m_pend = m_pend & r;
    @(negedge clk);
    chk_status(tag);
  endtask

  task automatic sp_pulse(input string tag);
    eng_sp_start = 1;
    if (m_pend && m_run && m_adapt) begin
      m_act = ~m_act; m_pend = 0;
    end
    @(negedge clk);
    eng_sp_start = 0;
    chk_status(tag);
  endtask

  // monitor: pop and compare read responses
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_rvalid) begin
        if (hq.size() == 0) chk(1'b0, "R9 unexpected host_rvalid", host_rdata, '0);
        else begin
          automatic logic [DW-1:0] e = hq.pop_front();
          automatic string t = hq_tag.pop_front();
          chk(host_rdata == e, t, host_rdata, e);
        end
      end
      if (eng_rvalid) begin
        if (eq.size() == 0) chk(1'b0, "R7 unexpected eng_rvalid", eng_rdata, '0);
        else begin
          automatic logic [DW-1:0] e = eq.pop_front();
          automatic string t = eq_tag.pop_front();
          chk(eng_rdata == e, t, eng_rdata, e);
        end
      end
    end
  end

  bit done = 0;
  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin ma[i] = '0; mb[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_status("R1 reset");
    eng_read(5, "R1 engine read after reset");
    host_op(0, 0, 5, '0, "R1 bank A cleared");
    host_op(0, 1, 127, '0, "R1 bank B cleared");

    // engine stopped: named bank
    host_op(1, 0, 3, 16'h1111, "R2 write A");
    host_op(1, 1, 3, 16'h2222, "R2 write B");
    host_op(1, 0, 127, 16'h7F7F, "R8 write last index");
    host_op(0, 0, 3, '0, "R2 read A");
    host_op(0, 1, 3, '0, "R2 read B");
    host_op(0, 0, 127, '0, "R8 read last index");
    eng_read(3, "R7 engine reads bank A");

    // out of range
    host_op(1, 0, 200, 16'hDEAD, "R8 oor write");
    host_op(0, 0, 72, '0, "R8 alias untouched");
    host_op(0, 1, 128, '0, "R8 oor read");
    eng_read(200, "R8 engine oor read");

    // request while stopped
    ctl(1, 1, "R6 request while stopped R10");
    ctl(0, 0, "R10 adapt off");

    // running, locked
    set_run(1, "R3 run");
    host_op(1, 0, 3, 16'h9999, "R3 locked write");
    host_op(0, 1, 3, '0, "R3 locked read");
    ctl(0, 1, "R6 request with adapt off");
    eng_read(3, "R3 contents unchanged");

    // running, adaptive
    ctl(1, 0, "R10 adapt on while running");
    host_op(1, 0, 3, 16'h3333, "R4 write steered to B");
    host_op(0, 0, 3, '0, "R4 read steered to B");
    eng_read(3, "R4 engine still on A");
    ctl(1, 1, "R5 request pending");
    repeat (3) @(negedge clk);
    chk_status("R5 waits for boundary");
    eng_read(3, "R5 no swap before boundary");
    sp_pulse("R5 swap at boundary");
    eng_read(3, "R7 engine reads bank B");
    host_op(1, 1, 3, 16'h4444, "R4 write steered to A");
    eng_read(3, "R4 engine keeps B");

    // dropped requests
    ctl(1, 1, "R5 second request");
    ctl(0, 0, "R6 adapt cleared drops request");
    sp_pulse("R6 no swap after drop");
    ctl(1, 1, "R5 third request");
    set_run(0, "R6 stop drops request");
    sp_pulse("R6 no swap while stopped");

    // stopped again: named bank
    host_op(0, 0, 3, '0, "R2 read A after runs");
    host_op(0, 1, 3, '0, "R2 read B after runs");
    eng_read(3, "R7 engine on B while stopped");

    repeat (3) @(negedge clk);
    chk(hq.size() == 0, "R9 host responses missing", DW'(hq.size()), '0);
    chk(eq.size() == 0, "R7 engine responses missing", DW'(eq.size()), '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule